// File: doc/BRIEF.md
# Watchdog and Periodic Alarm Down Counter

The block is a 24-bit down counter with a companion seed register. Software reaches both through three byte-wide registers on a simple register bus. Every write goes to the counter and to the seed. Any later reload takes its value from the seed.

Four control inputs set the behaviour: an enable, a mode select, an output steering select and an interrupt enable. In periodic alarm mode the counter counts a slow one-per-second strobe. Each time it reaches zero it sets a sticky flag, reloads from the seed and keeps running. In watchdog mode it counts a fast 4096-per-second strobe. Any read of the counter restarts it from the seed. When the count reaches zero the counter stops and sets the flag. It then either drives a reset request for 1024 fast strobes or pulses an interrupt for the same length.

While enable is low, the three bytes act as plain storage. An all-zero count always disables counting.

Top module: `wdt_alarm_ctr`

## Requirements
- R1: The counter bytes are at bus offsets 04h (bits 7:0), 05h (bits 15:8) and 06h (bits 23:16). A write to one of them loads that byte of both the counter and the seed.
- R2: With cfg_enable low, strobes do not change the count, and reads return exactly the bytes that were written.
- R3: A count of zero never decrements and never sets the flag. After the counter is written while it holds zero, counting starts only after cfg_enable has gone from 0 to 1.
- R4: In alarm mode (cfg_wdog=0), each tick_slow decrements the count. The decrement that would reach zero sets alarm_flag and reloads the seed instead. The flag stays set until a flag_clr strobe.
- R5: In alarm mode with cfg_enable high, a read of 04h returns the live low byte and latches the whole count. Reads of 05h and 06h return the latched bytes, while the counter keeps running.
- R6: In alarm mode, int_drive_low is 1 exactly when alarm_flag and cfg_int_en are both 1. cfg_steer has no effect, and rst_drive_low stays 0.
- R7: In watchdog mode (cfg_wdog=1), each tick_fast decrements the count. An enabled read of any byte returns the current value and reloads the seed into the counter.
- R8: In watchdog mode, the decrement from 1 to 0 sets alarm_flag. The count then stays at zero under further ticks.
- R9: In watchdog mode with cfg_steer=0, reaching zero raises rst_drive_low and access_block for 1024 tick_fast strobes. During that time bus writes and reads are ignored. At the end, alarm_flag clears and both outputs fall.
- R10: In watchdog mode with cfg_steer=1, reaching zero raises int_drive_low for 1024 tick_fast strobes if cfg_int_en=1, and alarm_flag clears when the pulse ends. If cfg_int_en=0, no pulse occurs and the flag stays set.
- R11: Neither flag_clr nor clearing cfg_int_en shortens a pulse. A counter write during an interrupt pulse updates the seed, and the count is reloaded and resumes when the pulse ends, with no enable toggle needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow | input | 1 | One-cycle strobe, once per second |
| tick_fast | input | 1 | One-cycle strobe, 4096 per second |
| cfg_enable | input | 1 | Counter enable; low makes the bytes plain storage |
| cfg_wdog | input | 1 | 0 = periodic alarm mode, 1 = watchdog mode |
| cfg_steer | input | 1 | Watchdog expiry target: 0 = reset pulse, 1 = interrupt |
| cfg_int_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Strobe that clears alarm_flag |
| acc_en | input | 1 | Bus access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Bus byte address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the access cycle |
| alarm_flag | output | 1 | Sticky alarm/timeout flag |
| int_drive_low | output | 1 | Pull interrupt line low |
| rst_drive_low | output | 1 | Pull reset line low |
| access_block | output | 1 | Register access inhibited |

## Verification
The assertions assume that tick_slow and tick_fast are single-cycle strobes. They also assume that the control inputs change only between accesses, never in the same cycle as a bus strobe. The bench drives every input on the falling edge and holds each strobe for exactly one clock. It raises a tick only while the bus is idle, and it changes configuration only while no count is in progress, except where a step deliberately alters cfg_int_en during a pulse.

// File: rtl/wdt_alarm_ctr.sv
module wdt_alarm_ctr #(
  parameter int          CW          = 24,
  parameter logic [7:0]  BASE        = 8'h04,
  parameter int          PULSE_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_slow,
  input  logic       tick_fast,
  input  logic       cfg_enable,
  input  logic       cfg_wdog,
  input  logic       cfg_steer,
  input  logic       cfg_int_en,
  input  logic       flag_clr,
  input  logic       acc_en,
  input  logic       acc_wr,
  input  logic [7:0] acc_addr,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  output logic       alarm_flag,
  output logic       int_drive_low,
  output logic       rst_drive_low,
  output logic       access_block
);
  localparam int         NB   = CW / 8;
  localparam logic [7:0] NB8  = 8'(NB);
  localparam int         PW   = $clog2(PULSE_TICKS);
  localparam logic [PW-1:0] PLAST = PW'(PULSE_TICKS - 1);

  logic [CW-1:0] cnt, seed, snap, wmask, cnt_wr, seed_nx;
  logic          flag, armed, en_q, pend, pulse_rst, pulse_int;
  logic [PW-1:0] pcnt;

  wire [7:0] off       = acc_addr - BASE;
  wire       hit       = acc_en && (off < NB8) && !pulse_rst;
  wire       wr        = hit && acc_wr;
  wire       rd        = hit && !acc_wr;
  wire       pulse_on  = pulse_rst | pulse_int;
  wire       tick      = cfg_wdog ? tick_fast : tick_slow;
  wire       run       = cfg_enable && armed && (cnt != '0) && !pulse_on;
  wire       pulse_end = pulse_on && tick_fast && (pcnt == PLAST);
  wire       restart   = rd && cfg_wdog && cfg_enable && !pulse_on;
  wire       hit_zero  = run && tick && (cnt == CW'(1)) && !wr && !restart;

  always_comb begin
    wmask = '0;
    for (int i = 0; i < NB; i++)
      if (off == 8'(i)) wmask[8*i +: 8] = 8'hFF;
    cnt_wr  = (cnt  & ~wmask) | ({NB{acc_wdata}} & wmask);
    seed_nx = wr ? ((seed & ~wmask) | ({NB{acc_wdata}} & wmask)) : seed;
  end

  always_comb begin
    acc_rdata = '0;
    if (rd)
      for (int i = 0; i < NB; i++)
        if (off == 8'(i))
          acc_rdata = (cfg_enable && !cfg_wdog && i != 0) ? snap[8*i +: 8] : cnt[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; seed <= '0; snap <= '0;
      flag <= 1'b0; armed <= 1'b0; en_q <= 1'b0; pend <= 1'b0;
      pulse_rst <= 1'b0; pulse_int <= 1'b0; pcnt <= '0;
    end else begin
      en_q <= cfg_enable;
      seed <= seed_nx;
      if (rd && off == 8'd0) snap <= cnt;

      if (wr && !pulse_on && cnt == '0) armed <= 1'b0;
      else if (cfg_enable && !en_q)      armed <= 1'b1;

      if (wr && !pulse_on)               cnt <= cnt_wr;
      else if (pulse_end && (pend || wr)) cnt <= seed_nx;
      else if (restart)                  cnt <= seed;
      else if (run && tick)              cnt <= (!cfg_wdog && cnt == CW'(1)) ? seed : cnt - CW'(1);

      if (hit_zero)                    flag <= 1'b1;
      else if (pulse_end)              flag <= 1'b0;
      else if (flag_clr && !pulse_on)  flag <= 1'b0;

      if (wr && pulse_on) pend <= 1'b1;
      if (hit_zero && cfg_wdog) begin
        if (!cfg_steer)     pulse_rst <= 1'b1;
        else if (cfg_int_en) pulse_int <= 1'b1;
        pcnt <= '0;
      end else if (pulse_end) begin
        pulse_rst <= 1'b0;
        pulse_int <= 1'b0;
        pend      <= 1'b0;
      end else if (pulse_on && tick_fast) begin
        pcnt <= pcnt + PW'(1);
      end
    end
  end

  assign alarm_flag    = flag;
  assign rst_drive_low = pulse_rst;
  assign access_block  = pulse_rst;
  assign int_drive_low = pulse_int | (!cfg_wdog && cfg_int_en && flag);

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !(rst_drive_low && int_drive_low && cfg_wdog && pulse_rst && pulse_int)); // R9
  AST_RST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rst_drive_low && !pulse_end) |=> rst_drive_low); // R11
  AST_FLAG_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n) pulse_end |=> !alarm_flag); // R9
  AST_ALARM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wdog && run && tick_slow && cnt == CW'(1) && !wr) |=> (cnt == $past(seed) && alarm_flag)); // R4
  AST_WD_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wdog && cnt == '0 && !wr && !restart && !pulse_end) |=> cnt == '0); // R8
  AST_STORE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !wr && !pulse_end) |=> $stable(cnt)); // R2
endmodule

// File: tb/sim_wdt_alarm_ctr.sv
`timescale 1ns/1ps
module sim_wdt_alarm_ctr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_slow = 0, tick_fast = 0, cfg_enable = 0, cfg_wdog = 0, cfg_steer = 0, cfg_int_en = 0, flag_clr = 0;
  logic acc_en = 0, acc_wr = 0;
  logic [7:0] acc_addr = 0, acc_wdata = 0, acc_rdata;
  logic alarm_flag, int_drive_low, rst_drive_low, access_block;
  int nchk = 0, nfail = 0;
  logic [7:0] b;
  logic [23:0] v;

  always #2 clk = ~clk;

  wdt_alarm_ctr u0 (.*);

  // {seed, slow ticks, expected count, expected flag}
  localparam logic [56:0] VEC [7] = '{
    {24'h000005, 8'd3, 24'h000002, 1'b0},
    {24'h000005, 8'd5, 24'h000005, 1'b1},
    {24'h000005, 8'd7, 24'h000003, 1'b1},
    {24'h000001, 8'd1, 24'h000001, 1'b1},
    {24'h010203, 8'd4, 24'h0101FF, 1'b0},
    {24'h000100, 8'd1, 24'h0000FF, 1'b0},
    {24'h000003, 8'd9, 24'h000003, 1'b1}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk); acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); acc_en = 1; acc_wr = 0; acc_addr = a;
    #1 d = acc_rdata;
    @(negedge clk); acc_en = 0;
  endtask

  task automatic wr24(input logic [23:0] x);
    wr(8'h04, x[7:0]); wr(8'h05, x[15:8]); wr(8'h06, x[23:16]);
  endtask

  task automatic rd24(output logic [23:0] x);
    logic [7:0] t;
    rd(8'h04, t); x[7:0] = t;
    rd(8'h05, t); x[15:8] = t;
    rd(8'h06, t); x[23:16] = t;
  endtask

  task automatic tk_s(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_slow = 1; @(negedge clk); tick_slow = 0;
    end
  endtask

  task automatic tk_f(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_fast = 1; @(negedge clk); tick_fast = 0;
    end
  endtask

  task automatic clr();
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  task automatic arm();
    @(negedge clk); cfg_enable = 0; @(negedge clk); cfg_enable = 1; @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    #600000;
    nchk++; nfail++;
    $display("FAIL watchdog: got hang expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset flag", alarm_flag, 0);
    chk("reset rst", rst_drive_low, 0);
    chk("reset int", int_drive_low, 0);
    chk("reset block", access_block, 0);
    rd(8'h04, b); chk("reset count", b, 0);

    // R1 R4 vector table, alarm mode
    for (int i = 0; i < 7; i++) begin
      cfg_enable = 0;
      wr24(VEC[i][56:33]);
      clr();
      arm();
      tk_s(int'(VEC[i][32:25]));
      rd24(v);
      chk("R1/R4 count", v, VEC[i][24:1]);
      chk("R4 flag", alarm_flag, VEC[i][0]);
    end

    // R2 storage
    cfg_enable = 0;
    wr24(24'hABCDEF); tk_s(3); rd24(v);
    chk("R2 storage", v, 24'hABCDEF);

    // R3 zero disable and arming
    wr24(24'h0); clr(); arm(); tk_s(3);
    chk("R3 zero flag", alarm_flag, 0);
    rd24(v); chk("R3 zero count", v, 0);
    wr24(24'h000005); tk_s(2); rd24(v);
    chk("R3 needs toggle", v, 5);
    arm(); tk_s(2); rd24(v);
    chk("R3 after toggle", v, 3);

    // R5 snapshot
    cfg_enable = 0; wr24(24'h010000); arm();
    rd(8'h04, b); chk("R5 live low", b, 8'h00);
    tk_s(1);
    rd(8'h05, b); chk("R5 latched mid", b, 8'h00);
    rd(8'h06, b); chk("R5 latched high", b, 8'h01);
    rd(8'h04, b); chk("R5 kept running", b, 8'hFF);

    // R6 alarm interrupt, steering ignored
    cfg_enable = 0; wr24(24'h000002); clr(); cfg_int_en = 1; cfg_steer = 1; arm();
    tk_s(1); chk("R6 int before", int_drive_low, 0);
    tk_s(1); chk("R6 int on flag", int_drive_low, 1);
    chk("R6 no reset", rst_drive_low, 0);
    @(negedge clk); cfg_int_en = 0; #1 chk("R6 int masked", int_drive_low, 0);
    tk_s(1); chk("R4 sticky", alarm_flag, 1);
    clr(); chk("R4 cleared", alarm_flag, 0);
    cfg_int_en = 1; #1 chk("R6 int idle", int_drive_low, 0);

    // R7 R8 R9 watchdog reset pulse
    @(negedge clk); cfg_int_en = 0; cfg_steer = 0; cfg_enable = 0; cfg_wdog = 1;
    wr24(24'h000004); arm();
    tk_f(2); rd(8'h04, b); chk("R7 count", b, 2);
    rd(8'h04, b); chk("R7 restart", b, 4);
    tk_f(3); chk("R8 not yet", alarm_flag, 0);
    tk_f(1);
    chk("R8 flag", alarm_flag, 1);
    chk("R9 rst low", rst_drive_low, 1);
    chk("R9 block", access_block, 1);
    wr(8'h04, 8'h77); clr();
    tk_f(1023);
    chk("R9 still low", rst_drive_low, 1);
    chk("R11 flag_clr no effect", alarm_flag, 1);
    tk_f(1);
    chk("R9 released", rst_drive_low, 0);
    chk("R9 unblocked", access_block, 0);
    chk("R9 flag cleared", alarm_flag, 0);
    rd(8'h04, b); chk("R9 write ignored", b, 0);
    rd(8'h04, b); chk("R9 seed kept", b, 4);

    // R10 steer to interrupt, disabled
    @(negedge clk); cfg_enable = 0; cfg_steer = 1; arm();
    tk_f(4);
    chk("R10 flag", alarm_flag, 1);
    chk("R10 no int", int_drive_low, 0);
    chk("R10 no rst", rst_drive_low, 0);
    tk_f(3); rd(8'h04, b); chk("R8 stopped", b, 0);
    clr(); chk("R10 flag cleared", alarm_flag, 0);

    // R10 R11 interrupt pulse
    @(negedge clk); cfg_int_en = 1;
    tk_f(4);
    chk("R10 int pulse", int_drive_low, 1);
    clr(); @(negedge clk); cfg_int_en = 0;
    wr(8'h04, 8'h03);
    chk("R11 int held", int_drive_low, 1);
    chk("R11 flag held", alarm_flag, 1);
    tk_f(1023); chk("R11 int still low", int_drive_low, 1);
    tk_f(1);
    chk("R10 int released", int_drive_low, 0);
    chk("R10 flag end", alarm_flag, 0);
    tk_f(1); rd(8'h04, b); chk("R11 resumed from seed", b, 2);

    summary();
    $finish;
  end
endmodule